// File: doc/BRIEF.md
# Metering Data Package Output Framer

This block sends one fixed-length data package over a byte-wide output each time it is asked to. A package always has sixteen bytes. It begins with a two-byte synchronisation header, then a mode byte and a status byte, and ends with twelve payload bytes taken from a register-file input bus. Each byte is marked by a one-cycle byte-valid pulse. The bytes are a fixed number of clocks apart.

A data-ready level frames every transfer. It rises a fixed lead time before the first byte and falls a fixed trail time after the last byte, so that a host can use it as an interrupt source. The low header byte tells the receiver what kind of package follows:
- a rolling package number from 0 to 5 during normal operation;
- a reserved code when the block is waiting for calibration data;
- a second reserved code when power-fail billing data is being sent.

A `pkgSel` output tells the register file which package it must present on the payload bus.

Top module: `meter_pkg_framer`

## Requirements
- R1: A package is exactly 16 bytes, in this order: high sync, low sync, mode, status, then the 12 payload bytes. The first byteValid pulse comes LEAD_CLKS (11) clocks after dataReady rises. Each later pulse comes BYTE_GAP (12) clocks after the one before it. byteValid is high for one cycle per byte. dataOut is zero whenever byteValid is low.
- R2: Byte 0 of every package is 0x80.
- R3: In byte 1, bits 7:3 are zero. In normal operation, bits 2:0 hold the package number and pkgSel holds the same number. The number is 0 for the first package after reset and counts 0,1,2,3,4,5,0,... over normal packages.
- R4: If calWait is high at the start and pwrFail is low, then all of the following hold:
  - byte 1 bits 2:0 are 110;
  - pkgSel is 0;
  - all 12 payload bytes are zero;
  - the normal package number does not advance.
- R5: If pwrFail is high at the start, byte 1 bits 2:0 are 111, whatever calWait is. pkgSel alternates 3,4,3,... over power-fail packages, and is 3 for the first one after reset. The normal package number does not advance.
- R6: In byte 2, bits MODE_W-1:0 are modeIn and the upper bits are zero.
- R7: Byte 3 equals statusIn.
- R8: Payload byte k (byte 4+k) equals payloadIn[8k+7:8k], for k from 0 to 11.
- R9: dataReady rises at the clock edge that samples startReq high while the block is idle. It falls TRAIL_CLKS (12) clocks after the last byte's edge. pkgSel holds its value while dataReady is high.
- R10: A startReq that arrives while a package is in progress is ignored. No extra bytes follow. dataReady stays low after the package ends. The package number advances only once.
- R11: While reset is asserted, dataReady, byteValid and dataOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one package; sampled only while idle |
| calWait | input | 1 | Waiting for calibration data (sampled at start) |
| pwrFail | input | 1 | Power-fail active (sampled at start, has priority) |
| modeIn | input | MODE_W | State of the mode pins |
| statusIn | input | 8 | External status bus value |
| payloadIn | input | 8*PAYLOAD_BYTES | Payload bytes, byte k at bits 8k+7:8k |
| dataOut | output | 8 | Output byte, zero between pulses |
| byteValid | output | 1 | One-cycle pulse marking each byte |
| dataReady | output | 1 | High around each transfer |
| pkgSel | output | 3 | Package the register file must present |

## Verification
Take the clock edge that samples startReq as edge 0. dataReady and pkgSel are due right after edge 0. Byte k is due right after edge 11+12k, so the last byte comes at edge 191, and dataReady falls at edge 203. The bench counts edges from the request edge and samples at the falling edge that follows each counted edge. At every one of those samples, it compares byteValid, dataOut and dataReady with a per-package expected schedule that it builds from its own model of the package number and the power-fail alternation. A request injected mid-package is covered by extending the observation window past the fall of dataReady.

// File: rtl/meter_pkg_types.sv
package meter_pkg_types;

  localparam logic [7:0] SYNC_HI    = 8'h80;
  localparam logic [2:0] CODE_CAL   = 3'b110;
  localparam logic [2:0] CODE_PFAIL = 3'b111;
  localparam logic [2:0] LAST_IDX   = 3'd5;
  localparam logic [2:0] PF_FIRST   = 3'd3;
  localparam logic [2:0] PF_SECOND  = 3'd4;
  localparam int         HDR_BYTES  = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_SEND,
    PH_TRAIL
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       start;
    logic       emit;
    logic [7:0] byteSel;
    logic       finish;
  } strobes_t;

endpackage

// File: rtl/meter_pkg_ctrl.sv
module meter_pkg_ctrl
  import meter_pkg_types::*;
#(
  parameter int LEAD_CLKS  = 11,
  parameter int TRAIL_CLKS = 12,
  parameter int BYTE_GAP   = 12,
  parameter int PKG_BYTES  = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  output strobes_t strb
);

  localparam int LT_MAX   = (LEAD_CLKS > TRAIL_CLKS) ? LEAD_CLKS : TRAIL_CLKS;
  localparam int MAX_CLKS = (LT_MAX > BYTE_GAP) ? LT_MAX : BYTE_GAP;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  localparam logic [CNT_W-1:0] LEAD_LAST  = CNT_W'(LEAD_CLKS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(BYTE_GAP - 1);
  localparam logic [CNT_W-1:0] TRAIL_LAST = CNT_W'(TRAIL_CLKS - 1);
  localparam logic [7:0]       BYTE_LAST  = 8'(PKG_BYTES - 1);

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [7:0]       byteCnt, byteCntNext;

  always_comb begin
    phaseNext   = phase;
    cntNext     = cnt + 1'b1;
    byteCntNext = byteCnt;
    strb        = '0;
    unique case (phase)
      PH_IDLE: begin
        cntNext = '0;
        if (startReq) begin
          strb.start  = 1'b1;
          byteCntNext = '0;
          phaseNext   = PH_LEAD;
        end
      end
      PH_LEAD, PH_SEND: begin
        if ((phase == PH_LEAD && cnt == LEAD_LAST) ||
            (phase == PH_SEND && cnt == GAP_LAST)) begin
          strb.emit    = 1'b1;
          strb.byteSel = byteCnt;
          cntNext      = '0;
          if (byteCnt == BYTE_LAST) begin
            phaseNext = PH_TRAIL;
          end else begin
            byteCntNext = byteCnt + 8'd1;
            phaseNext   = PH_SEND;
          end
        end
      end
      PH_TRAIL: begin
        if (cnt == TRAIL_LAST) begin
          strb.finish = 1'b1;
          cntNext     = '0;
          phaseNext   = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      byteCnt <= '0;
    end else begin
      phase   <= phaseNext;
      cnt     <= cntNext;
      byteCnt <= byteCntNext;
    end
  end

endmodule

// File: rtl/meter_pkg_datapath.sv
module meter_pkg_datapath
  import meter_pkg_types::*;
#(
  parameter int PAYLOAD_BYTES = 12,
  parameter int MODE_W        = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strb,
  input  logic                       calWait,
  input  logic                       pwrFail,
  input  logic [MODE_W-1:0]          modeIn,
  input  logic [7:0]                 statusIn,
  input  logic [8*PAYLOAD_BYTES-1:0] payloadIn,
  output logic [7:0]                 dataOut,
  output logic                       byteValid,
  output logic                       dataReady,
  output logic [2:0]                 pkgSel
);

  localparam int PAD_W = 8 - MODE_W;

  logic [2:0] normIdx;
  logic       pfSecond;
  logic [2:0] hdrCode;
  logic       calPkg;
  logic [7:0] payArr [PAYLOAD_BYTES];
  logic [7:0] paySel;
  logic [7:0] modeByte;
  logic [7:0] byteMux;

  // unpack payload bus into bytes
  for (genvar k = 0; k < PAYLOAD_BYTES; k++) begin : g_unpack
    assign payArr[k] = payloadIn[8*k +: 8];
  end

  if (PAD_W > 0) begin : g_modePad
    assign modeByte = {{PAD_W{1'b0}}, modeIn};
  end else begin : g_modeFull
    assign modeByte = modeIn[7:0];
  end

  always_comb begin
    paySel = '0;
    for (int k = 0; k < PAYLOAD_BYTES; k++) begin
      if (strb.byteSel == 8'(k + HDR_BYTES)) paySel = payArr[k];
    end
  end

  always_comb begin
    unique case (strb.byteSel)
      8'd0:    byteMux = SYNC_HI;
      8'd1:    byteMux = {5'b0, hdrCode};
      8'd2:    byteMux = modeByte;
      8'd3:    byteMux = statusIn;
      default: byteMux = calPkg ? 8'h00 : paySel;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normIdx   <= '0;
      pfSecond  <= 1'b0;
      hdrCode   <= '0;
      calPkg    <= 1'b0;
      pkgSel    <= '0;
      dataReady <= 1'b0;
      dataOut   <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= strb.emit;
      dataOut   <= strb.emit ? byteMux : 8'h00;
      if (strb.start) begin
        dataReady <= 1'b1;
        if (pwrFail) begin
          hdrCode  <= CODE_PFAIL;
          calPkg   <= 1'b0;
          pkgSel   <= pfSecond ? PF_SECOND : PF_FIRST;
          pfSecond <= ~pfSecond;
        end else if (calWait) begin
          hdrCode <= CODE_CAL;
          calPkg  <= 1'b1;
          pkgSel  <= '0;
        end else begin
          hdrCode <= normIdx;
          calPkg  <= 1'b0;
          pkgSel  <= normIdx;
          normIdx <= (normIdx == LAST_IDX) ? 3'd0 : normIdx + 3'd1;
        end
      end else if (strb.finish) begin
        dataReady <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/meter_pkg_framer.sv
module meter_pkg_framer
  import meter_pkg_types::*;
#(
  parameter int LEAD_CLKS     = 11,
  parameter int TRAIL_CLKS    = 12,
  parameter int BYTE_GAP      = 12,
  parameter int PAYLOAD_BYTES = 12,
  parameter int MODE_W        = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startReq,
  input  logic                       calWait,
  input  logic                       pwrFail,
  input  logic [MODE_W-1:0]          modeIn,
  input  logic [7:0]                 statusIn,
  input  logic [8*PAYLOAD_BYTES-1:0] payloadIn,
  output logic [7:0]                 dataOut,
  output logic                       byteValid,
  output logic                       dataReady,
  output logic [2:0]                 pkgSel
);

  localparam int PKG_BYTES = HDR_BYTES + PAYLOAD_BYTES;

  strobes_t strb;

  meter_pkg_ctrl #(
    .LEAD_CLKS (LEAD_CLKS),
    .TRAIL_CLKS(TRAIL_CLKS),
    .BYTE_GAP  (BYTE_GAP),
    .PKG_BYTES (PKG_BYTES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .strb    (strb)
  );

  meter_pkg_datapath #(
    .PAYLOAD_BYTES(PAYLOAD_BYTES),
    .MODE_W       (MODE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .calWait  (calWait),
    .pwrFail  (pwrFail),
    .modeIn   (modeIn),
    .statusIn (statusIn),
    .payloadIn(payloadIn),
    .dataOut  (dataOut),
    .byteValid(byteValid),
    .dataReady(dataReady),
    .pkgSel   (pkgSel)
  );

endmodule

// File: rtl/meter_pkg_framer_chk.sv
module meter_pkg_framer_chk #(
  parameter int MODE_W    = 2,
  parameter int PKG_BYTES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] dataOut,
  input logic       byteValid,
  input logic       dataReady,
  input logic [2:0] pkgSel
);

  logic [7:0] seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          seen <= '0;
    else if (!dataReady) seen <= '0;
    else if (byteValid)  seen <= seen + 8'd1;
  end

  a_r1_quiet_zero: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> dataOut == 8'h00);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  a_r1_inside_frame: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> dataReady);

  a_r9_full_count: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReady) |-> seen == 8'(PKG_BYTES));

  a_r2_sync_hi: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && seen == 8'd0) |-> dataOut == 8'h80);

  a_r3_sync_lo_upper: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && seen == 8'd1) |-> dataOut[7:3] == 5'd0);

  a_r3_norm_sel: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && seen == 8'd1 && dataOut[2:0] < 3'd6) |-> pkgSel == dataOut[2:0]);

  a_r4_cal_sel: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && seen == 8'd1 && dataOut[2:0] == 3'b110) |-> pkgSel == 3'd0);

  a_r5_pf_sel: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && seen == 8'd1 && dataOut[2:0] == 3'b111) |-> (pkgSel == 3'd3 || pkgSel == 3'd4));

  a_r10_sel_stable: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && $past(dataReady)) |-> $stable(pkgSel));

  if (MODE_W < 8) begin : g_modeChk
    a_r6_mode_upper: assert property (@(posedge clk) disable iff (!rstN)
      (byteValid && seen == 8'd2) |-> dataOut[7:MODE_W] == '0);
  end

endmodule

bind meter_pkg_framer meter_pkg_framer_chk #(
  .MODE_W   (MODE_W),
  .PKG_BYTES(PKG_BYTES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dataOut  (dataOut),
  .byteValid(byteValid),
  .dataReady(dataReady),
  .pkgSel   (pkgSel)
);

// File: tb/meter_pkg_framer_bench.sv
module meter_pkg_framer_bench;

  localparam int LEAD  = 11;
  localparam int GAP   = 12;
  localparam int TRAIL = 12;
  localparam int NB    = 16;
  localparam int LASTE = LEAD + (NB - 1) * GAP;   // 191
  localparam int FALLE = LASTE + TRAIL;           // 203

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        calWait = 1'b0;
  logic        pwrFail = 1'b0;
  logic [1:0]  modeIn = '0;
  logic [7:0]  statusIn = '0;
  logic [95:0] payloadIn = '0;
  logic [7:0]  dataOut;
  logic        byteValid;
  logic        dataReady;
  logic [2:0]  pkgSel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model
  logic [2:0] mIdx = 3'd0;
  bit         mPf = 1'b0;

  always #4 clk = ~clk;

  meter_pkg_framer u_meter_pkg_framer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .calWait(calWait),
    .pwrFail(pwrFail), .modeIn(modeIn), .statusIn(statusIn),
    .payloadIn(payloadIn), .dataOut(dataOut), .byteValid(byteValid),
    .dataReady(dataReady), .pkgSel(pkgSel)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expByte(int b, logic [2:0] code, bit cal,
                                         logic [1:0] md, logic [7:0] st, logic [95:0] pl);
    if (b == 0) return 8'h80;
    if (b == 1) return {5'b0, code};
    if (b == 2) return {6'b0, md};
    if (b == 3) return st;
    if (cal) return 8'h00;
    return pl[8*(b-4) +: 8];
  endfunction

  function automatic string byteReq(int b, bit cal, bit pf);
    if (b == 0) return "R2";
    if (b == 1) return pf ? "R5" : (cal ? "R4" : "R3");
    if (b == 2) return "R6";
    if (b == 3) return "R7";
    return cal ? "R4" : "R8";
  endfunction

  task automatic runPackage(bit cal, bit pf, bit poke);
    logic [2:0] code, sel;
    logic [1:0] md;
    logic [7:0] st;
    logic [95:0] pl;
    int nBytes;
    bit calEff;
    calEff = cal && !pf;
    if (pf) begin
      code = 3'b111; sel = mPf ? 3'd4 : 3'd3; mPf = !mPf;
    end else if (cal) begin
      code = 3'b110; sel = 3'd0;
    end else begin
      code = mIdx; sel = mIdx; mIdx = (mIdx == 3'd5) ? 3'd0 : mIdx + 3'd1;
    end
    md = 2'($urandom());
    st = 8'($urandom());
    pl = {$urandom(), $urandom(), $urandom()};
    @(negedge clk);
    calWait = cal; pwrFail = pf; modeIn = md; statusIn = st; payloadIn = pl;
    startReq = 1'b1;
    @(negedge clk);   // edge 0 has passed
    startReq = 1'b0;
    check("R9", "dataReady rise", 32'(dataReady), 32'd1);
    check(pf ? "R5" : (cal ? "R4" : "R3"), "pkgSel", 32'(pkgSel), 32'(sel));
    check("R1", "no byte at edge 0", 32'(byteValid), 32'd0);
    nBytes = 0;
    for (int cyc = 1; cyc <= FALLE + 4; cyc++) begin
      if (poke) startReq = (cyc == 40 || cyc == LASTE + 2);
      @(negedge clk);
      begin
        bit on;
        int b;
        on = (cyc >= LEAD) && ((cyc - LEAD) % GAP == 0) && ((cyc - LEAD) / GAP < NB);
        b = (cyc - LEAD) / GAP;
        check(cyc > FALLE ? (poke ? "R10" : "R1") : "R1", "byteValid", 32'(byteValid), 32'(on));
        if (on) begin
          nBytes++;
          check(byteReq(b, calEff, pf), $sformatf("byte %0d", b), 32'(dataOut),
                32'(expByte(b, code, calEff, md, st, pl)));
        end else begin
          check("R1", "dataOut idle", 32'(dataOut), 32'd0);
        end
        check(cyc >= FALLE ? (poke ? "R10" : "R9") : "R9", "dataReady",
              32'(dataReady), 32'(cyc < FALLE));
      end
    end
    startReq = 1'b0;
    check(poke ? "R10" : "R1", "byte count", 32'(nBytes), 32'(NB));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R11: reset state, with inputs active
    startReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", "dataReady in reset", 32'(dataReady), 32'd0);
    check("R11", "byteValid in reset", 32'(byteValid), 32'd0);
    check("R11", "dataOut in reset", 32'(dataOut), 32'd0);
    startReq = 1'b0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "dataReady after reset", 32'(dataReady), 32'd0);
    // R3 wrap over seven normal packages
    for (int i = 0; i < 7; i++) runPackage(1'b0, 1'b0, 1'b0);
    // R4 calibration wait, R5 power-fail with priority over calWait
    runPackage(1'b1, 1'b0, 1'b0);
    runPackage(1'b0, 1'b1, 1'b0);
    runPackage(1'b1, 1'b1, 1'b0);
    runPackage(1'b0, 1'b0, 1'b0);
    // R10 request during a transfer
    runPackage(1'b0, 1'b0, 1'b1);
    runPackage(1'b0, 1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 20; i++) begin
      runPackage(($urandom() % 5) == 0, ($urandom() % 5) == 0, ($urandom() % 4) == 0);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule